// File: doc/BRIEF.md
# Paged External RAM Window Controller

The block sits on the bus side of an 8-bit expansion port and exposes a large external RAM through one fixed 256-byte window, page 0xFD. A set of byte-wide paging latches sits at fixed I/O addresses just below 0xFD00, at 0xFCFF, 0xFCFE and 0xFCFD. Together they supply the upper bytes of a wide extended address, and the offset inside the window supplies the low byte. The block decodes the window and latch accesses. It drives the RAM address, write data and write strobe, and it returns read data onto the bus only when this board is selected.

The block runs in one of two modes. In aliasing mode it discards every extended-address bit above its RAM size, so the whole extended space folds onto its own RAM. In claimed-region mode it answers only when the top nibble of the extended address equals a configured value. A filtered copy of the window select goes on to boards further down the cable, and it is active only for extended addresses whose bits above bit 19 are all zero.

Top module: `pgwin_ctrl`

## Requirements
- R1: After the asynchronous reset every paging latch reads as 0x00, so with a window offset of zero `ram_addr_o` is all zeros.
- R2: A bus write to 0xFCFF loads extended-address bits 15..8 on the clock edge that ends the cycle.
- R3: A bus write to 0xFCFE loads bits 23..16 and a write to 0xFCFD loads bits 31..24 (with the default of three latches).
- R4: A `brk_i` pulse clears all latches to 0x00 on the next clock edge.
- R5: During a write cycle to page 0xFD while selected, `ram_we_o` is high, `ram_wdata_o` equals `data_i`, and `ram_addr_o[7:0]` equals the window offset.
- R6: During a read cycle to page 0xFD while selected, `data_oe_o` is high and `data_o` equals `ram_rdata_i`.
- R7: In aliasing mode, `ram_addr_o` is extended-address bits RAM_AW-1..0, and the extended-address bits above them have no effect on it.
- R8: In claimed-region mode, the board is selected only when extended-address bits 31..28 equal MATCH_NIB. Otherwise window reads leave `data_oe_o` low and window writes leave `ram_we_o` low.
- R9: Reads of a latch address drive the bus with that latch's value only when READBACK_EN is 1. With the default of 0, `data_oe_o` stays low on those reads.
- R10: `down_sel_o` is high only during a bus cycle to page 0xFD whose extended-address bits 31..20 are all zero.
- R11: Read cycles to a latch address, and writes to 0xFCFC (which is not a latch), leave every latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; a cycle completes on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| brk_i | input | 1 | Synchronous reset strobe that clears the latches |
| cyc_i | input | 1 | Bus cycle valid |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data to the CPU (zero when not enabled) |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| ram_addr_o | output | RAM_AW | External RAM address |
| ram_wdata_o | output | 8 | External RAM write data |
| ram_we_o | output | 1 | External RAM write strobe |
| ram_rdata_i | input | 8 | External RAM read data |
| down_sel_o | output | 1 | Filtered window select for downstream boards |

## Verification
The bench builds two instances that share one bus. The first uses the defaults: aliasing, no read-back and a 20-bit RAM. The second uses claimed-region mode with MATCH_NIB = 1, read-back on and a 16-bit RAM. With the same latch writes, one top-nibble value therefore shows both folding and claiming at once. Claim misses, latch read-back and its absence, and the downstream filter all come into reach from a single stimulus stream.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  localparam logic [7:0] WIN_PAGE   = 8'hFD;
  localparam logic [7:0] IO_PAGE    = 8'hFC;
  localparam logic [7:0] LATCH_BASE = 8'hFF;  // latch k sits at IO_PAGE:(LATCH_BASE-k)
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
  import pgwin_pkg::*;
#(
  parameter int NUM_LATCH = 3
) (
  input  logic                 cyc_i,
  input  logic                 rnw_i,
  input  logic [15:0]          addr_i,
  output logic                 win_hit_o,
  output logic [NUM_LATCH-1:0] latch_wr_o,
  output logic [NUM_LATCH-1:0] latch_rd_o
);
  logic io_page;
  assign io_page   = cyc_i && (addr_i[15:8] == IO_PAGE);
  assign win_hit_o = cyc_i && (addr_i[15:8] == WIN_PAGE);

  for (genvar k = 0; k < NUM_LATCH; k++) begin : g_lat
    localparam logic [7:0] OFF = LATCH_BASE - 8'(k);
    logic hit;
    assign hit           = io_page && (addr_i[7:0] == OFF);
    assign latch_wr_o[k] = hit && !rnw_i;
    assign latch_rd_o[k] = hit && rnw_i;
  end
endmodule

// File: rtl/pgwin_latch_bank.sv
module pgwin_latch_bank #(
  parameter int NUM_LATCH = 3,
  localparam int LW = 8 * NUM_LATCH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 brk_i,
  input  logic [NUM_LATCH-1:0] wr_i,
  input  logic [7:0]           data_i,
  output logic [LW-1:0]        latches_o
);
  for (genvar k = 0; k < NUM_LATCH; k++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= 8'h00;
      else if (brk_i)   q <= 8'h00;
      else if (wr_i[k]) q <= data_i;
    end
    assign latches_o[8*k +: 8] = q;
  end
endmodule

// File: rtl/pgwin_region.sv
module pgwin_region #(
  parameter int          EXT_W     = 32,
  parameter int          RAM_AW    = 20,
  parameter int          PASS_AW   = 20,
  parameter bit          MATCH_EN  = 1'b0,
  parameter logic [3:0]  MATCH_NIB = 4'h1
) (
  input  logic [EXT_W-1:0]  ext_i,
  output logic              own_sel_o,
  output logic              pass_o,
  output logic [RAM_AW-1:0] ram_addr_o
);
  assign ram_addr_o = ext_i[RAM_AW-1:0];
  assign pass_o     = (ext_i[EXT_W-1:PASS_AW] == '0);

  if (MATCH_EN) begin : g_claim
    assign own_sel_o = (ext_i[EXT_W-1 -: 4] == MATCH_NIB);
  end else begin : g_alias
    assign own_sel_o = 1'b1;
  end
endmodule

// File: rtl/pgwin_ctrl.sv
module pgwin_ctrl #(
  parameter int         NUM_LATCH   = 3,
  parameter int         RAM_AW      = 20,
  parameter int         PASS_AW     = 20,
  parameter bit         MATCH_EN    = 1'b0,
  parameter logic [3:0] MATCH_NIB   = 4'h1,
  parameter bit         READBACK_EN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              brk_i,
  input  logic              cyc_i,
  input  logic              rnw_i,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              ram_we_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              down_sel_o
);
  localparam int LW    = 8 * NUM_LATCH;
  localparam int EXT_W = LW + 8;

  logic                 win_hit, own_sel, pass, win_rd, lat_rd_any;
  logic [NUM_LATCH-1:0] lat_wr, lat_rd;
  logic [LW-1:0]        latches;
  logic [EXT_W-1:0]     ext;
  logic [7:0]           lat_q;

  pgwin_decode #(.NUM_LATCH(NUM_LATCH)) u_dec (
    .cyc_i, .rnw_i, .addr_i,
    .win_hit_o(win_hit), .latch_wr_o(lat_wr), .latch_rd_o(lat_rd)
  );

  pgwin_latch_bank #(.NUM_LATCH(NUM_LATCH)) u_lat (
    .clk_i, .rst_ni, .brk_i, .wr_i(lat_wr), .data_i, .latches_o(latches)
  );

  assign ext = {latches, addr_i[7:0]};

  pgwin_region #(
    .EXT_W(EXT_W), .RAM_AW(RAM_AW), .PASS_AW(PASS_AW),
    .MATCH_EN(MATCH_EN), .MATCH_NIB(MATCH_NIB)
  ) u_reg (
    .ext_i(ext), .own_sel_o(own_sel), .pass_o(pass), .ram_addr_o
  );

  always_comb begin
    lat_q = 8'h00;
    for (int k = 0; k < NUM_LATCH; k++)
      if (lat_rd[k]) lat_q = latches[8*k +: 8];
  end

  assign lat_rd_any  = READBACK_EN && (|lat_rd);
  assign win_rd      = win_hit && rnw_i && own_sel;
  assign data_oe_o   = win_rd || lat_rd_any;
  assign data_o      = win_rd ? ram_rdata_i : (lat_rd_any ? lat_q : 8'h00);
  assign ram_we_o    = win_hit && !rnw_i && own_sel;
  assign ram_wdata_o = data_i;
  assign down_sel_o  = win_hit && pass;
endmodule

// File: rtl/pgwin_ctrl_chk.sv
module pgwin_ctrl_chk #(
  parameter int RAM_AW = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              brk_i,
  input logic              cyc_i,
  input logic              rnw_i,
  input logic [15:0]       addr_i,
  input logic [7:0]        data_i,
  input logic              data_oe_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              down_sel_o
);
  // R5
  we_only_window_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (cyc_i && !rnw_i && addr_i[15:8] == 8'hFD));

  // R6
  oe_only_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (cyc_i && rnw_i));

  // R10
  pass_only_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_sel_o |-> (cyc_i && addr_i[15:8] == 8'hFD));

  // R4
  brk_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> (ram_addr_o[RAM_AW-1:8] == '0));

  if (RAM_AW >= 16) begin : g_l0
    // R2
    page_latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_i && !rnw_i && addr_i == 16'hFCFF && !brk_i) |=> (ram_addr_o[15:8] == $past(data_i)));
  end
endmodule

bind pgwin_ctrl pgwin_ctrl_chk #(.RAM_AW(RAM_AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .brk_i(brk_i), .cyc_i(cyc_i), .rnw_i(rnw_i),
  .addr_i(addr_i), .data_i(data_i), .data_oe_o(data_oe_o),
  .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .down_sel_o(down_sel_o)
);

// File: tb/pgwin_ctrl_tb_top.sv
module pgwin_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, brk = 1'b0, cyc = 1'b0, rnw = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wd = 8'h00;

  logic [7:0]  a_do, a_wd, a_rd, b_do, b_wd, b_rd;
  logic        a_oe, a_we, a_ds, b_oe, b_we, b_ds;
  logic [19:0] a_ra;
  logic [15:0] b_ra;

  int n_chk = 0, n_bad = 0;
  logic [7:0] lat [3];  // bench model of the three latches

  always #2 clk = ~clk;

  assign a_rd = a_ra[7:0] ^ a_ra[15:8] ^ {4'h0, a_ra[19:16]};
  assign b_rd = b_ra[7:0] ^ b_ra[15:8] ^ 8'hA5;

  pgwin_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .cyc_i(cyc), .rnw_i(rnw),
    .addr_i(addr), .data_i(wd), .data_o(a_do), .data_oe_o(a_oe),
    .ram_addr_o(a_ra), .ram_wdata_o(a_wd), .ram_we_o(a_we),
    .ram_rdata_i(a_rd), .down_sel_o(a_ds)
  );

  pgwin_ctrl #(.RAM_AW(16), .MATCH_EN(1'b1), .MATCH_NIB(4'h1), .READBACK_EN(1'b1)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .cyc_i(cyc), .rnw_i(rnw),
    .addr_i(addr), .data_i(wd), .data_o(b_do), .data_oe_o(b_oe),
    .ram_addr_o(b_ra), .ram_wdata_o(b_wd), .ram_we_o(b_we),
    .ram_rdata_i(b_rd), .down_sel_o(b_ds)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ext_of(input logic [7:0] off);
    return {lat[2], lat[1], lat[0], off};
  endfunction

  // drive a bus cycle; combinational outputs are valid after return
  task automatic drive(input logic [15:0] a, input logic [7:0] d, input logic r);
    @(negedge clk);
    cyc = 1'b1; addr = a; wd = d; rnw = r;
    #1;
  endtask

  task automatic commit();
    @(posedge clk);
    if (cyc && !rnw && addr[15:8] == 8'hFC && addr[7:0] >= 8'hFD)
      lat[8'hFF - addr[7:0]] = wd;
    @(negedge clk);
    cyc = 1'b0; rnw = 1'b1;
    #1;
  endtask

  task automatic wr_latch(input logic [15:0] a, input logic [7:0] d);
    drive(a, d, 1'b0);
    commit();
  endtask

  task automatic t_reset();
    check("R1 a addr", 32'(a_ra), 32'h0);
    check("R1 b addr", 32'(b_ra), 32'h0);
    check("R1 idle oe", {30'h0, a_oe, b_oe}, 32'h0);
    check("R10 idle down_sel", {30'h0, a_ds, b_ds}, 32'h0);
  endtask

  task automatic t_latch_load();
    logic [31:0] e;
    wr_latch(16'hFCFF, 8'h12);
    wr_latch(16'hFCFE, 8'h04);
    wr_latch(16'hFCFD, 8'h00);
    drive(16'hFD56, 8'h00, 1'b1);
    e = ext_of(8'h56);
    check("R2 R3 a addr", 32'(a_ra), 32'(e[19:0]));
    check("R2 b addr", 32'(b_ra), 32'(e[15:0]));
    check("R6 a oe", 32'(a_oe), 32'h1);
    check("R6 a data", 32'(a_do), 32'(e[7:0] ^ e[15:8] ^ {4'h0, e[19:16]}));
    check("R8 b unclaimed oe", 32'(b_oe), 32'h0);
    check("R10 low region down_sel", {30'h0, a_ds, b_ds}, 32'h3);
    commit();
  endtask

  task automatic t_win_write();
    logic [31:0] e;
    drive(16'hFD9A, 8'hC3, 1'b0);
    e = ext_of(8'h9A);
    check("R5 a we", 32'(a_we), 32'h1);
    check("R5 a wdata", 32'(a_wd), 32'hC3);
    check("R5 a addr", 32'(a_ra), 32'(e[19:0]));
    check("R8 b unclaimed we", 32'(b_we), 32'h0);
    commit();
    check("R5 we idle", {30'h0, a_we, b_we}, 32'h0);
  endtask

  task automatic t_alias_claim();
    logic [31:0] e;
    wr_latch(16'hFCFD, 8'h15);
    drive(16'hFD56, 8'h00, 1'b1);
    e = ext_of(8'h56);
    check("R7 a addr folds", 32'(a_ra), 32'h41256);
    check("R7 a oe", 32'(a_oe), 32'h1);
    check("R8 b claimed oe", 32'(b_oe), 32'h1);
    check("R8 b data", 32'(b_do), 32'(e[7:0] ^ e[15:8] ^ 8'hA5));
    check("R10 high region down_sel", {30'h0, a_ds, b_ds}, 32'h0);
    commit();
    drive(16'hFD01, 8'h5A, 1'b0);
    check("R8 b claimed we", 32'(b_we), 32'h1);
    check("R5 b wdata", 32'(b_wd), 32'h5A);
    check("R7 a we", 32'(a_we), 32'h1);
    commit();
  endtask

  task automatic t_claim_miss();
    wr_latch(16'hFCFD, 8'h25);
    drive(16'hFD10, 8'h00, 1'b1);
    check("R8 miss b oe", 32'(b_oe), 32'h0);
    check("R8 miss b data", 32'(b_do), 32'h0);
    check("R7 a still oe", 32'(a_oe), 32'h1);
    commit();
    drive(16'hFD10, 8'h99, 1'b0);
    check("R8 miss b we", 32'(b_we), 32'h0);
    commit();
  endtask

  task automatic t_readback();
    drive(16'hFCFE, 8'h00, 1'b1);
    check("R9 a no readback oe", 32'(a_oe), 32'h0);
    check("R9 b readback oe", 32'(b_oe), 32'h1);
    check("R9 b readback FCFE", 32'(b_do), 32'(lat[1]));
    commit();
    drive(16'hFCFF, 8'h00, 1'b1);
    check("R9 b readback FCFF", 32'(b_do), 32'(lat[0]));
    commit();
  endtask

  task automatic t_ignored();
    drive(16'hFCFF, 8'hEE, 1'b1);
    commit();
    wr_latch(16'hFCFC, 8'h77);
    drive(16'hFD00, 8'h00, 1'b1);
    check("R11 a upper addr", 32'(a_ra), {12'h0, lat[1][3:0], lat[0], 8'h00});
    check("R11 page latch", 32'(a_ra[15:8]), 32'h12);
    commit();
    drive(16'hFCFD, 8'h00, 1'b1);
    check("R11 top latch kept", 32'(b_do), 32'h25);
    commit();
  endtask

  task automatic t_break();
    @(negedge clk);
    brk = 1'b1;
    @(posedge clk);
    lat[0] = 8'h00; lat[1] = 8'h00; lat[2] = 8'h00;
    @(negedge clk);
    brk = 1'b0;
    drive(16'hFD3C, 8'h00, 1'b1);
    check("R4 a addr cleared", 32'(a_ra), 32'h3C);
    check("R4 b addr cleared", 32'(b_ra), 32'h3C);
    check("R10 after break down_sel", 32'(a_ds), 32'h1);
    commit();
    drive(16'hFCFD, 8'h00, 1'b1);
    check("R4 top latch cleared", 32'(b_do), 32'h00);
    commit();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    lat[0] = 8'h00; lat[1] = 8'h00; lat[2] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_latch_load();
    t_win_write();
    t_alias_claim();
    t_claim_miss();
    t_readback();
    t_ignored();
    t_break();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule